// File: doc/BRIEF.md
# QPSK Quarter-Rate IF Modulator

This block turns a serial stream of data bits into a digital intermediate-frequency waveform. Incoming bits are grouped in pairs. Each pair becomes one symbol with a bipolar in-phase level and a bipolar quadrature level. The two levels are mixed onto a carrier that runs at exactly one quarter of the sample clock, and the result leaves as one signed sample per clock.

At a quarter of the sample rate, the cosine reference steps through 1, 0, -1, 0 and the sine reference through 0, 1, 0, -1. Each output sample is therefore one of the two levels or its negative, and no multiplier, phase accumulator or table is needed. Pulse shaping is a plain hold: each symbol stays in force for an integer number of carrier periods. The carrier phase runs freely from reset and is never realigned to a symbol boundary.

Bits enter through a valid/ready handshake. When no complete pair is available, the output is zero and its valid flag is low. Emission resumes on the next symbol boundary after a pair arrives. A default setup of a 50 MHz sample clock, a 12.5 MHz carrier and two carrier cycles per symbol gives 8 samples per symbol.

Top module: `qpsk_if_mod`

## Requirements
- R1: Of each accepted bit pair, the earlier bit sets the in-phase sign and the later bit sets the quadrature sign. Bit value 0 gives +AMPLITUDE and bit value 1 gives -AMPLITUDE.
- R2: A valid sample equals I·cos − Q·sin at the current carrier index. For carrier index 0, 1, 2, 3 this is +I, −Q, −I, +Q in that order.
- R3: The carrier index is 0 in the output sample registered on the first clock edge after reset is released. It then increases by one modulo 4 on every edge, whether or not symbols are being sent.
- R4: Every symbol produces exactly 4·HOLD_CYCLES consecutive valid samples.
- R5: If the next pair is already complete when a symbol ends, the next symbol follows with no invalid cycle between them.
- R6: While no symbol is being emitted, if_valid is 0 and if_sample is 0.
- R7: A synchronous reset drives if_valid and if_sample to 0 and bit_ready to 1. It also discards any half-collected pair, so the first bit accepted after reset starts a new pair.
- R8: A bit is taken only on a clock edge where both bit_valid and bit_ready are 1. While a complete pair waits for the symbol in progress to finish, bit_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | bit_in holds a bit to be taken |
| bit_ready | output | 1 | Modulator can take a bit on this edge |
| if_sample | output | SAMPLE_W | Signed modulated sample |
| if_valid | output | 1 | if_sample carries a symbol sample |

## Verification
A pairing register that has slipped by one bit swaps I and Q, or carries a stale bit into the next symbol. This shows up at the ports as wrong signs in the very first samples of the affected symbol. A symbol counter that is off by one makes a symbol one sample short or long, which moves every later sample against the bench's own symbol index within one symbol period. A carrier index that stalls or restarts breaks the +I, −Q, −I, +Q rotation on the next valid sample. Because the bench works out the expected index from the edge count since reset, such an error is caught even when it happens during idle gaps.

// File: rtl/qpsk_mod_pkg.sv
package qpsk_mod_pkg;

  // Bipolar level selected by one data bit: 0 -> +amp, 1 -> -amp.
  function automatic int dibit_level(input logic neg, input int amp);
    return neg ? -amp : amp;
  endfunction

  // Cosine of a quarter-rate carrier at index ph.
  function automatic int carrier_cos(input logic [1:0] ph);
    case (ph)
      2'd0:    return 1;
      2'd2:    return -1;
      default: return 0;
    endcase
  endfunction

  // Sine of a quarter-rate carrier at index ph.
  function automatic int carrier_sin(input logic [1:0] ph);
    case (ph)
      2'd1:    return 1;
      2'd3:    return -1;
      default: return 0;
    endcase
  endfunction

  // Quadrature mix: I*cos - Q*sin.
  function automatic int fs4_mix(input int i_lvl, input int q_lvl, input logic [1:0] ph);
    return i_lvl * carrier_cos(ph) - q_lvl * carrier_sin(ph);
  endfunction

endpackage

// File: rtl/qpsk_dibit_pack.sv
module qpsk_dibit_pack (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_in,
  input  logic       bit_valid,
  output logic       bit_ready,
  input  logic       pair_take,
  output logic       pair_full,
  output logic [1:0] pair_bits
);

  logic       half_have_q;
  logic       half_bit_q;
  logic       full_q;
  logic [1:0] pair_q;
  logic       accept;

  assign bit_ready = !full_q;
  assign accept    = bit_valid && bit_ready;
  assign pair_full = full_q;
  assign pair_bits = pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_have_q <= 1'b0;
      half_bit_q  <= 1'b0;
      full_q      <= 1'b0;
      pair_q      <= 2'b00;
    end else begin
      if (pair_take) full_q <= 1'b0;
      if (accept) begin
        if (!half_have_q) begin
          half_have_q <= 1'b1;
          half_bit_q  <= bit_in;
        end else begin
          half_have_q <= 1'b0;
          pair_q      <= {half_bit_q, bit_in};
          full_q      <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/qpsk_symbol_timer.sv
module qpsk_symbol_timer #(
  parameter int SYM_LEN = 8,
  parameter int CNT_W   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pair_full,
  input  logic [1:0] pair_bits,
  output logic       pair_take,
  output logic       sym_load,
  output logic       sym_active,
  output logic [1:0] sym_dibit
);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       dib_q;
  logic             last;

  assign last       = active_q && (cnt_q == CNT_W'(SYM_LEN - 1));
  assign sym_load   = pair_full && (!active_q || last);
  assign pair_take  = sym_load;
  assign sym_active = active_q;
  assign sym_dibit  = dib_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dib_q    <= 2'b00;
    end else if (sym_load) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      dib_q    <= pair_bits;
    end else if (last) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/qpsk_fs4_mixer.sv
module qpsk_fs4_mixer
  import qpsk_mod_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2047
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sym_active,
  input  logic [1:0]                 sym_dibit,
  output logic signed [SAMPLE_W-1:0] if_sample,
  output logic                       if_valid
);

  generate
    if (AMPLITUDE <= 0 || AMPLITUDE >= (1 << (SAMPLE_W - 1))) begin : g_bad_amp
      $error("AMPLITUDE must be positive and fit a signed SAMPLE_W sample");
    end
  endgenerate

  logic [1:0]                 ph_q;
  int                         i_lvl;
  int                         q_lvl;
  int                         mix_full;
  logic signed [SAMPLE_W-1:0] mix_w;

  always_comb begin
    i_lvl    = dibit_level(sym_dibit[1], AMPLITUDE);
    q_lvl    = dibit_level(sym_dibit[0], AMPLITUDE);
    mix_full = fs4_mix(i_lvl, q_lvl, ph_q);
    mix_w    = SAMPLE_W'(mix_full);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= 2'd0;
      if_sample <= '0;
      if_valid  <= 1'b0;
    end else begin
      ph_q      <= ph_q + 2'd1;
      if_valid  <= sym_active;
      if_sample <= sym_active ? mix_w : '0;
    end
  end

endmodule

// File: rtl/qpsk_if_mod.sv
module qpsk_if_mod #(
  parameter int SAMPLE_W    = 12,
  parameter int AMPLITUDE   = 2047,
  parameter int HOLD_CYCLES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_in,
  input  logic                       bit_valid,
  output logic                       bit_ready,
  output logic signed [SAMPLE_W-1:0] if_sample,
  output logic                       if_valid
);

  localparam int SYM_LEN = 4 * HOLD_CYCLES;
  localparam int CNT_W   = $clog2(SYM_LEN);

  generate
    if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
    end
  endgenerate

  logic       pair_full;
  logic [1:0] pair_bits;
  logic       pair_take;
  logic       sym_load;
  logic       sym_active;
  logic [1:0] sym_dibit;

  qpsk_dibit_pack u_pack (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .pair_take (pair_take),
    .pair_full (pair_full),
    .pair_bits (pair_bits)
  );

  qpsk_symbol_timer #(
    .SYM_LEN (SYM_LEN),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .pair_full  (pair_full),
    .pair_bits  (pair_bits),
    .pair_take  (pair_take),
    .sym_load   (sym_load),
    .sym_active (sym_active),
    .sym_dibit  (sym_dibit)
  );

  qpsk_fs4_mixer #(
    .SAMPLE_W  (SAMPLE_W),
    .AMPLITUDE (AMPLITUDE)
  ) u_mix (
    .clk        (clk),
    .rst        (rst),
    .sym_active (sym_active),
    .sym_dibit  (sym_dibit),
    .if_sample  (if_sample),
    .if_valid   (if_valid)
  );

endmodule

// File: rtl/qpsk_if_mod_chk.sv
module qpsk_if_mod_chk #(
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2047,
  parameter int SYM_LEN   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bit_ready,
  input logic signed [SAMPLE_W-1:0] if_sample,
  input logic                       if_valid,
  input logic                       sym_load,
  input logic                       sym_active,
  input logic                       pair_full,
  input logic                       pair_take
);

  localparam logic signed [SAMPLE_W-1:0] POS = SAMPLE_W'(AMPLITUDE);
  localparam logic signed [SAMPLE_W-1:0] NEG = -POS;

  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)             run_cnt <= '0;
    else if (sym_load)   run_cnt <= 16'd1;
    else if (sym_active) run_cnt <= run_cnt + 16'd1;
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !if_valid |-> (if_sample == '0));

  p_level_set_r2: assert property (@(posedge clk) disable iff (rst)
    if_valid |-> (if_sample == POS || if_sample == NEG));

  p_valid_lag_r5: assert property (@(posedge clk) disable iff (rst)
    sym_active |=> if_valid);

  p_reload_len_r4: assert property (@(posedge clk) disable iff (rst)
    (sym_load && sym_active) |-> (run_cnt == 16'(SYM_LEN)));

  p_end_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sym_active) |-> ($past(run_cnt) == 16'(SYM_LEN)));

  p_pair_held_r8: assert property (@(posedge clk) disable iff (rst)
    (pair_full && !pair_take) |=> pair_full);

  p_reset_state_r7: assert property (@(posedge clk)
    $past(rst) |-> (!if_valid && bit_ready && if_sample == '0));

endmodule

bind qpsk_if_mod qpsk_if_mod_chk #(
  .SAMPLE_W  (SAMPLE_W),
  .AMPLITUDE (AMPLITUDE),
  .SYM_LEN   (SYM_LEN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_ready  (bit_ready),
  .if_sample  (if_sample),
  .if_valid   (if_valid),
  .sym_load   (sym_load),
  .sym_active (sym_active),
  .pair_full  (pair_full),
  .pair_take  (pair_take)
);

// File: tb/sim_qpsk_if_mod.sv
`timescale 1ns/1ps
module sim_qpsk_if_mod;

  localparam int W    = 12;
  localparam int A    = 2047;
  localparam int HOLD = 2;
  localparam int SL   = 4 * HOLD;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                bit_in = 1'b0;
  logic                bit_valid = 1'b0;
  logic                bit_ready;
  logic signed [W-1:0] if_sample;
  logic                if_valid;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int edges = 0;
  int nsamp = 0;
  int nb = 0;
  logic bits_acc [0:1023];
  int first_v = -1;
  int last_v = -1;
  int cnt_v = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qpsk_if_mod #(.SAMPLE_W(W), .AMPLITUDE(A), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .if_sample(if_sample), .if_valid(if_valid)
  );

  // Expected sample: index 0 -> +I, 1 -> -Q, 2 -> -I, 3 -> +Q (R1, R2)
  function automatic int exp_sample(input logic b_i, input logic b_q, input int ph);
    case (ph)
      0:       return b_i ? -A :  A;
      1:       return b_q ?  A : -A;
      2:       return b_i ?  A : -A;
      default: return b_q ? -A :  A;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  // Monitor: every valid sample against bench symbol list and edge-derived phase
  always @(negedge clk) begin
    if (rst) begin
      nsamp = 0;
    end else if (edges > 0) begin
      if (if_valid) begin
        int k;
        int ph;
        int e;
        k  = nsamp / SL;
        ph = (edges - 1) % 4;
        if (2 * k + 1 < nb) begin
          e = exp_sample(bits_acc[2*k], bits_acc[2*k+1], ph);
          check(int'(if_sample) == e, "R1/R2/R3", "sample", int'(if_sample), e);
        end else begin
          check(1'b0, "R4", "valid sample beyond accepted symbols", nsamp, (nb / 2) * SL);
        end
        nsamp++;
        if (first_v < 0) first_v = edges;
        last_v = edges;
        cnt_v++;
      end else begin
        check(if_sample == '0, "R6", "idle sample", int'(if_sample), 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      nfail++;
      nchk++;
      $display("FAIL R5 watchdog: cycles %0d expected below %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      bit_valid = 1'b0;
      bit_in    = 1'($urandom);
      @(negedge clk);
    end
    bit_valid = 1'b1;
    bit_in    = b;
    while (!bit_ready) @(negedge clk);
    bits_acc[nb] = b;
    nb++;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_in    = 1'($urandom);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    nb = 0;
    rst = 1'b0;
    check(if_valid == 1'b0, "R7", "valid after reset", int'(if_valid), 0);
    check(if_sample == '0, "R7", "sample after reset", int'(if_sample), 0);
    check(bit_ready == 1'b1, "R7", "ready after reset", int'(bit_ready), 1);
  endtask

  task automatic drain();
    for (int t = 0; t < 4000; t++) begin
      if (nsamp == (nb / 2) * SL && !if_valid) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(nsamp == (nb / 2) * SL, "R4", "samples emitted", nsamp, (nb / 2) * SL);
  endtask

  task automatic clear_span();
    first_v = -1;
    last_v  = -1;
    cnt_v   = 0;
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    @(negedge clk);
    do_reset();

    // Directed: all four dibits back to back; ready drops with a pair waiting (R8)
    clear_span();
    send_bit(1'b0, 0); send_bit(1'b0, 0);
    send_bit(1'b0, 0); send_bit(1'b1, 0);
    check(bit_ready == 1'b0, "R8", "ready while pair waits", int'(bit_ready), 0);
    send_bit(1'b1, 0); send_bit(1'b0, 0);
    send_bit(1'b1, 0); send_bit(1'b1, 0);
    drain();
    check(last_v - first_v + 1 == 4 * SL, "R5", "burst span", last_v - first_v + 1, 4 * SL);
    check(cnt_v == 4 * SL, "R4", "burst sample count", cnt_v, 4 * SL);

    // Single isolated symbol after an idle gap of odd length (R3, R4)
    repeat (5) @(negedge clk);
    clear_span();
    send_bit(1'b1, 3); send_bit(1'b0, 0);
    drain();
    check(cnt_v == SL, "R4", "isolated symbol length", cnt_v, SL);

    // Random traffic with random gaps, ignored bits in the gaps (R1, R2, R3, R8)
    for (int n = 0; n < 300; n++) send_bit(1'($urandom), int'($urandom_range(0, 6)));
    drain();

    // Reset with a half-collected pair: the stray bit is discarded (R7)
    send_bit(1'b1, 2);
    repeat (4) @(negedge clk);
    do_reset();
    clear_span();
    send_bit(1'b0, 1); send_bit(1'b0, 0);
    drain();
    check(cnt_v == SL, "R7", "symbol after half-pair reset", cnt_v, SL);

    // Reset in the middle of a symbol
    send_bit(1'b1, 0); send_bit(1'b1, 0);
    repeat (4) @(negedge clk);
    do_reset();
    repeat (10) @(negedge clk);
    check(if_valid == 1'b0, "R6", "idle after aborted symbol", int'(if_valid), 0);

    // Long continuous stream: no gaps (R5)
    clear_span();
    for (int n = 0; n < 40; n++) send_bit(1'($urandom), 0);
    drain();
    check(last_v - first_v + 1 == 20 * SL, "R5", "stream span", last_v - first_v + 1, 20 * SL);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule